// File: doc/BRIEF.md
# Crosspoint Parallel Command Controller

This block is the digital control plane of a video routing matrix with eight outputs and eight inputs, programmed through a parallel command word. Each word has a 3-bit output address and a 4-bit command code. A host presents the word and raises a write strobe, which is gated by an active-high and an active-low chip enable. The strobe is brought into the system clock domain by a two-flop synchroniser with a rising-edge detector. On the detected edge the word is decoded and applied to a first rank of per-output routing registers, or to the buffer enables.

The first rank is staged. It reaches the second rank, which drives the analog switch controls, in four ways: on a rising edge of the latch pin in edge mode; continuously while the latch pin is low in level mode; as a side effect of every buffer-enable command; or by a software-latch command while the latch pin is high. The second rank supplies a 3-bit input select and a ground-input flag for each output. A separate register holds one buffer enable per output. The address, code and enable inputs must be held steady around the write strobe. The edge/level mode input is a static setting.

Top module: `xpt_cmd_ctrl`

## Requirements
- R1: A write is accepted only if ce_hi is 1 and ce_lo_n is 0 while wr_strobe rises. In any other case the strobe changes neither the routing nor the enables.
- R2: Codes 0000 to 0111 set the first-rank select of the addressed output to the code value and clear its ground flag. The outputs route_sel (field i at bits 3i+2..3i) and gnd_sel[i] change only when a transfer to the second rank happens.
- R3: Code 1000 sets the first-rank ground flag of the addressed output. After a transfer, gnd_sel of that output reads 1.
- R4: Code 1011 clears buf_en of the addressed output only, and its routing is kept. Code 1100 sets it again, and the earlier routing is still in place.
- R5: Code 1101 clears all of buf_en. Code 1110 sets all of buf_en. Neither command alters the routing held in either rank.
- R6: Each code from 1011 to 1110 also copies the first rank into the second rank.
- R7: Code 1111 copies the first rank into the second rank only if the latch pin is high. With the latch pin low it has no effect.
- R8: With edge_mode at 1, the second rank loads on a rising edge of latch_pin. First-rank writes made while the latch pin holds its level do not reach the outputs.
- R9: With edge_mode at 0, the second rank follows the first rank while latch_pin is low and holds while latch_pin is high.
- R10: After reset, buf_en is all zeros. The routing after reset is undefined.
- R11: Codes 1001 and 1010, and input codes that are not below the input count, change neither the routing nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_strobe | input | 1 | Asynchronous write strobe, acts on its rising edge |
| ce_hi | input | 1 | Active-high chip enable for the write strobe |
| ce_lo_n | input | 1 | Active-low chip enable for the write strobe |
| addr | input | 3 | Output address of the command word |
| code | input | 4 | Command code of the command word |
| latch_pin | input | 1 | Asynchronous rank-transfer control |
| edge_mode | input | 1 | 1: transfer on latch rise; 0: transparent while latch is low |
| route_sel | output | 24 | Second-rank input select, 3 bits per output |
| gnd_sel | output | 8 | Second-rank ground-input flag per output |
| buf_en | output | 8 | Buffer enable per output |

## Verification
The bench stages routing in the first rank and confirms that the outputs hold their old value until a transfer happens. A design that loads the second rank on every write would show new routes too early. It runs the software latch with the latch pin low and then with it high. It also runs every enable command without a latch pulse, so a design that ignores the latch level, or that leaves out the implicit transfer, gives the wrong route values. It checks that disabling one output, or all of them, keeps their routing across the later re-enable. It checks that writes with either chip enable inactive, and the serial-only codes, leave all state unchanged. Level mode is tested both for following the first rank while the latch is low and for freezing while it is high.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    OP_ROUTE  = 3'd0,
    OP_GND    = 3'd1,
    OP_OFF1   = 3'd2,
    OP_ON1    = 3'd3,
    OP_OFFALL = 3'd4,
    OP_ONALL  = 3'd5,
    OP_SWLAT  = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  // Map a command code to an operation; input codes at or above n_in are illegal
  function automatic op_e decode_op(input logic [CODE_W-1:0] c, input int n_in);
    op_e r;
    if (!c[3]) begin
      r = (int'(c) < n_in) ? OP_ROUTE : OP_NONE;
    end else begin
      case (c[2:0])
        3'b000:  r = OP_GND;
        3'b011:  r = OP_OFF1;
        3'b100:  r = OP_ON1;
        3'b101:  r = OP_OFFALL;
        3'b110:  r = OP_ONALL;
        3'b111:  r = OP_SWLAT;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

  // Operations that also move the first rank into the second rank
  function automatic logic op_forces_xfer(input op_e o);
    return (o == OP_OFF1) || (o == OP_ON1) || (o == OP_OFFALL) || (o == OP_ONALL);
  endfunction

endpackage

// File: rtl/xpt_sync_edge.sv
module xpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      prev  <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~prev;
endmodule

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
  import xpt_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int SEL_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output op_e               op,
  output logic [SEL_W-1:0]  sel_val,
  output logic              forces_xfer
);
  always_comb begin
    op          = decode_op(code, N_IN);
    forces_xfer = op_forces_xfer(op);
  end

  generate
    if (SEL_W < CODE_W) begin : g_narrow
      assign sel_val = code[SEL_W-1:0];
    end else begin : g_wide
      assign sel_val = SEL_W'(code);
    end
  endgenerate
endmodule

// File: rtl/xpt_rank_store.sv
module xpt_rank_store
  import xpt_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_evt,
  input  op_e                    op,
  input  logic                   forces_xfer,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SEL_W-1:0]       sel_val,
  input  logic                   latch_lvl,
  input  logic                   latch_rise,
  input  logic                   edge_mode,
  output logic                   xfer,
  output logic [N_OUT*SEL_W-1:0] r1_sel,
  output logic [N_OUT*SEL_W-1:0] r2_sel,
  output logic [N_OUT-1:0]       r2_gnd,
  output logic [N_OUT-1:0]       en
);
  logic [N_OUT-1:0] r1_gnd;
  logic             xfer_hw;
  logic             xfer_sw;

  assign xfer_hw = edge_mode ? latch_rise : ~latch_lvl;
  assign xfer_sw = wr_evt & (forces_xfer | ((op == OP_SWLAT) & latch_lvl));
  assign xfer    = xfer_hw | xfer_sw;

  genvar g;
  generate
    for (g = 0; g < N_OUT; g++) begin : g_out
      logic hit;
      assign hit = wr_evt && (addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r1_sel[g*SEL_W +: SEL_W] <= '0;
          r1_gnd[g]                <= 1'b0;
        end else if (hit && op == OP_ROUTE) begin
          r1_sel[g*SEL_W +: SEL_W] <= sel_val;
          r1_gnd[g]                <= 1'b0;
        end else if (hit && op == OP_GND) begin
          r1_gnd[g]                <= 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r2_sel[g*SEL_W +: SEL_W] <= '0;
          r2_gnd[g]                <= 1'b0;
        end else if (xfer) begin
          r2_sel[g*SEL_W +: SEL_W] <= r1_sel[g*SEL_W +: SEL_W];
          r2_gnd[g]                <= r1_gnd[g];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en[g] <= 1'b0;
        end else if (wr_evt) begin
          if (op == OP_OFFALL || (hit && op == OP_OFF1)) en[g] <= 1'b0;
          else if (op == OP_ONALL || (hit && op == OP_ON1)) en[g] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xpt_cmd_ctrl.sv
module xpt_cmd_ctrl
  import xpt_pkg::*;
#(
  parameter int N_OUT       = 8,
  parameter int N_IN        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int ADDR_W     = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_strobe,
  input  logic                   ce_hi,
  input  logic                   ce_lo_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CODE_W-1:0]      code,
  input  logic                   latch_pin,
  input  logic                   edge_mode,
  output logic [N_OUT*SEL_W-1:0] route_sel,
  output logic [N_OUT-1:0]       gnd_sel,
  output logic [N_OUT-1:0]       buf_en
);
  logic             wr_gated;
  logic             wr_lvl;
  logic             wr_evt;
  logic             lat_lvl;
  logic             lat_rise;
  logic             xfer;
  logic             forces_xfer;
  op_e              op;
  logic [SEL_W-1:0] sel_val;
  logic [N_OUT*SEL_W-1:0] r1_sel;

  assign wr_gated = wr_strobe & ce_hi & ~ce_lo_n;

  xpt_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wr_gated), .level(wr_lvl), .rise(wr_evt)
  );

  xpt_sync_edge #(.STAGES(SYNC_STAGES)) u_lat_sync (
    .clk(clk), .rst_n(rst_n), .async_in(latch_pin), .level(lat_lvl), .rise(lat_rise)
  );

  xpt_cmd_decode #(.N_IN(N_IN), .SEL_W(SEL_W)) u_dec (
    .code(code), .op(op), .sel_val(sel_val), .forces_xfer(forces_xfer)
  );

  xpt_rank_store #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .op(op), .forces_xfer(forces_xfer),
    .addr(addr), .sel_val(sel_val), .latch_lvl(lat_lvl), .latch_rise(lat_rise),
    .edge_mode(edge_mode), .xfer(xfer), .r1_sel(r1_sel), .r2_sel(route_sel),
    .r2_gnd(gnd_sel), .en(buf_en)
  );

  logic unused_wr_lvl;
  assign unused_wr_lvl = wr_lvl;
endmodule

// File: rtl/xpt_cmd_ctrl_chk.sv
module xpt_cmd_ctrl_chk
  import xpt_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_evt,
  input op_e                    op,
  input logic                   lat_rise,
  input logic                   edge_mode,
  input logic                   xfer,
  input logic [N_OUT*SEL_W-1:0] r1_sel,
  input logic [N_OUT*SEL_W-1:0] route_sel,
  input logic [N_OUT-1:0]       buf_en
);
  // R10
  reset_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> buf_en == '0);

  // R2
  route_moves_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(route_sel) |-> $past(xfer));

  // R6
  xfer_copies_rank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> route_sel == $past(r1_sel));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !lat_rise && !wr_evt) |=> $stable(route_sel));

  // R5
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && op == OP_OFFALL) |=> buf_en == '0);

  // R5
  all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && op == OP_ONALL) |=> buf_en == '1);

  // R11
  illegal_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && op == OP_NONE) |=> $stable(buf_en));

  // R1
  en_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_en) |-> $past(wr_evt));

  // R1
  single_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

bind xpt_cmd_ctrl xpt_cmd_ctrl_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .op(op), .lat_rise(lat_rise),
  .edge_mode(edge_mode), .xfer(xfer), .r1_sel(r1_sel), .route_sel(route_sel),
  .buf_en(buf_en)
);

// File: tb/xpt_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module xpt_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        ce_hi = 1'b1;
  logic        ce_lo_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  code = '0;
  logic        latch_pin = 1'b1;
  logic        edge_mode = 1'b1;
  logic [23:0] route_sel;
  logic [7:0]  gnd_sel;
  logic [7:0]  buf_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xpt_cmd_ctrl u_xpt_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .addr(addr), .code(code), .latch_pin(latch_pin), .edge_mode(edge_mode),
    .route_sel(route_sel), .gnd_sel(gnd_sel), .buf_en(buf_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] fld(input logic [23:0] v, input int i);
    return v[i*3 +: 3];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [2:0] a, input logic [3:0] c,
                        input logic hi = 1'b1, input logic lo_n = 1'b0);
    addr = a; code = c; ce_hi = hi; ce_lo_n = lo_n;
    wait_cyc(2);
    wr_strobe = 1'b1;
    wait_cyc(6);
    wr_strobe = 1'b0;
    wait_cyc(4);
    ce_hi = 1'b1; ce_lo_n = 1'b0;
  endtask

  task automatic pulse_latch();
    latch_pin = 1'b0;
    wait_cyc(5);
    latch_pin = 1'b1;
    wait_cyc(6);
  endtask

  task automatic t_reset();
    chk("R10 enables after reset", buf_en, 8'h00);
  endtask

  task automatic t_edge_route();
    logic [23:0] snap;
    pulse_latch();
    snap = route_sel;
    wr_cmd(3'd0, 4'd5);
    wr_cmd(3'd3, 4'd2);
    wr_cmd(3'd5, 4'd0);
    chk("R8 staged writes not visible", route_sel, snap);
    pulse_latch();
    chk("R2 out0 select", fld(route_sel, 0), 3'd5);
    chk("R2 out3 select", fld(route_sel, 3), 3'd2);
    chk("R2 out5 select", fld(route_sel, 5), 3'd0);
    chk("R2 ground flags clear", {gnd_sel[0], gnd_sel[3], gnd_sel[5]}, 3'b000);
  endtask

  task automatic t_ground();
    wr_cmd(3'd3, 4'b1000);
    chk("R3 ground not yet visible", gnd_sel[3], 1'b0);
    pulse_latch();
    chk("R3 ground flag out3", gnd_sel[3], 1'b1);
    wr_cmd(3'd3, 4'd2);
    pulse_latch();
    chk("R2 route clears ground", gnd_sel[3], 1'b0);
  endtask

  task automatic t_enables();
    wr_cmd(3'd1, 4'd7);
    chk("R8 out1 staged only", fld(route_sel, 1) == 3'd7 ? 1'b0 : 1'b1, 1'b1);
    wr_cmd(3'd0, 4'b1110);
    chk("R5 all on", buf_en, 8'hFF);
    chk("R6 implicit transfer out1", fld(route_sel, 1), 3'd7);
    wr_cmd(3'd2, 4'd4);
    wr_cmd(3'd2, 4'b1011);
    chk("R4 single off", buf_en, 8'hFB);
    chk("R6 transfer on single off", fld(route_sel, 2), 3'd4);
    wr_cmd(3'd2, 4'b1100);
    chk("R4 single on", buf_en, 8'hFF);
    chk("R4 routing kept out2", fld(route_sel, 2), 3'd4);
    wr_cmd(3'd6, 4'b1101);
    chk("R5 all off", buf_en, 8'h00);
    wr_cmd(3'd6, 4'b1110);
    chk("R5 all on again", buf_en, 8'hFF);
    chk("R5 routing kept out0", fld(route_sel, 0), 3'd5);
    chk("R5 routing kept out1", fld(route_sel, 1), 3'd7);
  endtask

  task automatic t_swlatch();
    wr_cmd(3'd4, 4'd6);
    wr_cmd(3'd0, 4'b1111);
    chk("R7 soft latch with latch high", fld(route_sel, 4), 3'd6);
    latch_pin = 1'b0;
    wait_cyc(4);
    wr_cmd(3'd4, 4'd1);
    wr_cmd(3'd0, 4'b1111);
    chk("R7 soft latch ignored with latch low", fld(route_sel, 4), 3'd6);
    latch_pin = 1'b1;
    wait_cyc(6);
    chk("R8 latch rise loads out4", fld(route_sel, 4), 3'd1);
  endtask

  task automatic t_gating();
    logic [23:0] snap;
    snap = route_sel;
    wr_cmd(3'd5, 4'd3, 1'b0, 1'b0);
    pulse_latch();
    chk("R1 write blocked by ce_hi low", route_sel, snap);
    wr_cmd(3'd5, 4'd3, 1'b1, 1'b1);
    pulse_latch();
    chk("R1 write blocked by ce_lo_n high", route_sel, snap);
    wr_cmd(3'd0, 4'b1101, 1'b0, 1'b1);
    chk("R1 gated all-off ignored", buf_en, 8'hFF);
    wr_cmd(3'd5, 4'd3);
    pulse_latch();
    chk("R1 enabled write accepted", fld(route_sel, 5), 3'd3);
  endtask

  task automatic t_illegal();
    logic [23:0] snap;
    logic [7:0]  gsnap;
    snap = route_sel;
    gsnap = gnd_sel;
    wr_cmd(3'd0, 4'b1010);
    chk("R11 code 1010 enables", buf_en, 8'hFF);
    wr_cmd(3'd1, 4'b1001);
    chk("R11 code 1001 enables", buf_en, 8'hFF);
    pulse_latch();
    chk("R11 routing unchanged", route_sel, snap);
    chk("R11 ground unchanged", gnd_sel, gsnap);
  endtask

  task automatic t_level();
    edge_mode = 1'b0;
    wait_cyc(2);
    wr_cmd(3'd6, 4'd4);
    chk("R9 held while latch high", fld(route_sel, 6) == 3'd4 ? 1'b0 : 1'b1, 1'b1);
    latch_pin = 1'b0;
    wait_cyc(5);
    chk("R9 transparent when latch low", fld(route_sel, 6), 3'd4);
    wr_cmd(3'd6, 4'd0);
    chk("R9 follows write while low", fld(route_sel, 6), 3'd0);
    latch_pin = 1'b1;
    wait_cyc(5);
    wr_cmd(3'd6, 4'd2);
    chk("R9 frozen while latch high", fld(route_sel, 6), 3'd0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_edge_route();
    t_ground();
    t_enables();
    t_swlatch();
    t_gating();
    t_illegal();
    t_level();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule